// File: doc/BRIEF.md
# Clause 22 Management Interface Master

This block runs one Clause 22 management transaction at a time on a two-wire management bus: a clock it generates itself (MDC) and a shared bidirectional data line (MDIO). A start pulse with a read/write select, a 5-bit PHY address, a 5-bit register address and 16 bits of write data launches a frame. For a write, the master drives the whole frame. For a read, it hands the data line to the PHY partway through the frame and shifts in 16 data bits. When the frame is over, `done` pulses for one cycle with the read result on `rdData`.

MDC is derived from the system clock. Each MDC half-period lasts `HALF_DIV` system cycles. The data line leaves the block as an output-enable/output pair for an external tristate pad. The pad's input comes back through a synchronizer of `SYNC_STAGES` flops before any bit is sampled.

A frame is built from these bit positions: pulses 0–31 carry preamble, 32–33 start, 34–35 opcode, 36–40 PHY address, 41–45 register address. After that the frame depends on direction:
- **Write:** the turnaround and data occupy pulses 46–63, and pulse 64 is a released trailing pulse.
- **Read:** pulse 46 is released, pulses 47–62 carry PHY data, and pulse 63 is a released trailing pulse.

Top module: `mdio_master`

## Requirements
- R1: Out of reset, `mdc` is 0, `mdioOe` is 0, `busy` is 0 and `done` is 0.
- R2: Every frame begins with 32 driven 1 bits followed by the start pattern 0,1, each bit presented to the PHY on a rising edge of `mdc`.
- R3: After the start pattern the master sends the opcode (1,0 for a read when `isWrite`=0; 0,1 for a write when `isWrite`=1), then the 5-bit PHY address, then the 5-bit register address, each field MSB first.
- R4: In a write frame the master then drives turnaround 1,0 and the 16 data bits MSB first, keeping `mdioOe` high for exactly the first 64 rising edges of the frame.
- R5: In a read frame `mdioOe` is high for exactly the first 46 rising edges. `rdData[15-j]` equals the line value the PHY presents after rising edge 47+j (j = 0..15, edges counted from 0). That value is sampled after the falling edge that follows it.
- R6: After the data phase one more `mdc` pulse is issued with the line released, so a read frame has 64 rising edges and a write frame 65.
- R7: `mdc` is low whenever `busy` is low. Each bit is a low phase followed by a high phase of `HALF_DIV` system cycles each, so `busy` stays high for (rising edges × 2 × `HALF_DIV`) cycles.
- R8: `mdioOut` and `mdioOe` change only in cycles where `mdc` is low.
- R9: A `start` pulse while `busy` is high is ignored. The running frame is unchanged and no second frame follows it.
- R10: `busy` rises the cycle after an accepted `start`. `done` is a single-cycle pulse in the first cycle with `busy` low. `rdData` then holds the read value, or 0 after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Single-cycle transaction request |
| isWrite | input | 1 | 1 = write frame, 0 = read frame |
| phyAddr | input | 5 | Target PHY address |
| regAddr | input | 5 | Target register address |
| wrData | input | 16 | Data for a write frame |
| rdData | output | 16 | Data returned by a read frame |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | Data line value when driven |
| mdioOe | output | 1 | Data line output enable |
| mdioIn | input | 1 | Data line value from the pad |

## Verification
The assertions assume that `start` is the only way a frame begins and that `HALF_DIV` is at least 2. They also assume that the PHY never needs the line during the first 46 pulses of a read. The bench keeps `start` to one-cycle pulses from tasks and uses `HALF_DIV`=4. Its PHY model drives only from pulse 46 to pulse 62 of a read frame. It flags any cycle in which the PHY model and the master would drive the line together.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int ADDR_W          = 5;
  localparam int DATA_W          = 16;
  localparam int PRE_BITS        = 32;
  localparam int HDR_BITS        = PRE_BITS + 2 + 2 + 2 * ADDR_W;  // 46
  localparam int FRAME_W         = HDR_BITS + 2 + DATA_W;          // 64
  localparam int WR_LAST_BIT     = FRAME_W;                        // released trailing pulse
  localparam int RD_LAST_BIT     = HDR_BITS + 1 + DATA_W;          // 63
  localparam int RD_FIRST_SAMPLE = HDR_BITS + 2;                   // 48
  localparam int IDX_W           = $clog2(WR_LAST_BIT + 1);

  localparam logic [1:0] START_PAT = 2'b01;
  localparam logic [1:0] OP_READ   = 2'b10;
  localparam logic [1:0] OP_WRITE  = 2'b01;
  localparam logic [1:0] TA_WRITE  = 2'b10;

  typedef enum logic {ST_IDLE, ST_RUN} state_t;

  typedef struct packed {
    logic load;     // accepted start: build frame, clear read data
    logic shift;    // bit boundary: present next frame bit
    logic capture;  // read sample point
    logic drive;    // master owns the data line
  } ctrlStrobes_t;

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int HALF_DIV = 25
) (
  input  logic clk,
  input  logic rstN,
  input  logic run,
  output logic mdc,
  output logic halfEnd
);

  localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_DIV - 1);

  logic [CNT_W-1:0] halfCnt;
  logic             phaseHigh;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      halfCnt   <= '0;
      phaseHigh <= 1'b0;
    end else if (!run) begin
      halfCnt   <= '0;
      phaseHigh <= 1'b0;
    end else if (halfCnt == CNT_LAST) begin
      halfCnt   <= '0;
      phaseHigh <= ~phaseHigh;
    end else begin
      halfCnt <= halfCnt + 1'b1;
    end
  end

  assign halfEnd = run && (halfCnt == CNT_LAST);
  assign mdc     = phaseHigh;

endmodule

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         isWrite,
  input  logic         halfEnd,
  input  logic         mdcHigh,
  output logic         busy,
  output logic         done,
  output ctrlStrobes_t strobes
);

  state_t           state;
  logic [IDX_W-1:0] bitIdx;
  logic             wrLatched;
  logic [IDX_W-1:0] lastBit;
  logic [IDX_W-1:0] driveEnd;
  logic             advance;
  logic             finish;

  assign busy = (state == ST_RUN);

  always_comb begin
    lastBit  = wrLatched ? IDX_W'(WR_LAST_BIT) : IDX_W'(RD_LAST_BIT);
    driveEnd = wrLatched ? IDX_W'(FRAME_W)     : IDX_W'(HDR_BITS);
    advance  = busy && halfEnd && mdcHigh;
    finish   = advance && (bitIdx == lastBit);

    strobes.load    = (state == ST_IDLE) && start;
    strobes.shift   = advance;
    strobes.drive   = busy && (bitIdx < driveEnd);
    strobes.capture = busy && !wrLatched && halfEnd && !mdcHigh &&
                      (bitIdx >= IDX_W'(RD_FIRST_SAMPLE));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitIdx    <= '0;
      wrLatched <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= finish;
      if (strobes.load) begin
        state     <= ST_RUN;
        bitIdx    <= '0;
        wrLatched <= isWrite;
      end else if (finish) begin
        state  <= ST_IDLE;
        bitIdx <= '0;
      end else if (advance) begin
        bitIdx <= bitIdx + 1'b1;
      end
    end
  end

  // R9: a frame in progress is never restarted from bit 0
  p_no_restart_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && bitIdx != '0) |=> (!busy || bitIdx != '0));

  // R10: done never lasts more than one cycle
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

// File: rtl/mdio_dpath.sv
module mdio_dpath
  import mdio_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic              isWrite,
  input  logic [ADDR_W-1:0] phyAddr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              mdioIn,
  output logic              mdioOut,
  output logic              mdioOe,
  output logic [DATA_W-1:0] rdData
);

  logic [FRAME_W-1:0] frameSh;
  logic [FRAME_W-1:0] frameInit;
  logic               lineSync;

  always_comb begin
    if (isWrite)
      frameInit = {{PRE_BITS{1'b1}}, START_PAT, OP_WRITE, phyAddr, regAddr,
                   TA_WRITE, wrData};
    else
      frameInit = {{PRE_BITS{1'b1}}, START_PAT, OP_READ, phyAddr, regAddr,
                   {(FRAME_W - HDR_BITS){1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      frameSh <= '0;
    else if (strobes.load)
      frameSh <= frameInit;
    else if (strobes.shift)
      frameSh <= {frameSh[FRAME_W-2:0], 1'b0};
  end

  assign mdioOut = frameSh[FRAME_W-1];
  assign mdioOe  = strobes.drive;

  generate
    if (SYNC_STAGES <= 1) begin : g_sync_single
      logic syncQ;
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= 1'b1;
        else       syncQ <= mdioIn;
      end
      assign lineSync = syncQ;
    end else begin : g_sync_chain
      logic [SYNC_STAGES-1:0] syncQ;
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], mdioIn};
      end
      assign lineSync = syncQ[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN)
      rdData <= '0;
    else if (strobes.load)
      rdData <= '0;
    else if (strobes.capture)
      rdData <= {rdData[DATA_W-2:0], lineSync};
  end

endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int HALF_DIV    = 25,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              isWrite,
  input  logic [ADDR_W-1:0] phyAddr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              busy,
  output logic              done,
  output logic              mdc,
  output logic              mdioOut,
  output logic              mdioOe,
  input  logic              mdioIn
);

  ctrlStrobes_t strobes;
  logic         halfEnd;

  mdio_clkgen #(.HALF_DIV(HALF_DIV)) uClk (
    .clk     (clk),
    .rstN    (rstN),
    .run     (busy),
    .mdc     (mdc),
    .halfEnd (halfEnd)
  );

  mdio_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .isWrite (isWrite),
    .halfEnd (halfEnd),
    .mdcHigh (mdc),
    .busy    (busy),
    .done    (done),
    .strobes (strobes)
  );

  mdio_dpath #(.SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .isWrite (isWrite),
    .phyAddr (phyAddr),
    .regAddr (regAddr),
    .wrData  (wrData),
    .mdioIn  (mdioIn),
    .mdioOut (mdioOut),
    .mdioOe  (mdioOe),
    .rdData  (rdData)
  );

  // R7 / R1: idle bus keeps the clock low and the line released
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!mdc && !mdioOe));

  // R8: the line only moves while the clock is low
  p_line_moves_low_r8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable({mdioOe, mdioOut}) |-> !mdc);

  // R10: done only appears once the frame has ended
  p_done_not_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

endmodule

// File: tb/tb_mdio_master.sv
`timescale 1ns/1ps
module tb_mdio_master;

  localparam int H = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        isWrite = 1'b0;
  logic [4:0]  phyAddr = '0;
  logic [4:0]  regAddr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        busy, done, mdc, mdioOut, mdioOe;
  logic        mdioIn;

  logic        phyDrv = 1'b0;
  logic        phyVal = 1'b1;
  logic        curWr = 1'b0;
  logic [15:0] phyPattern = '0;

  int riseCnt = 0, drivenRises = 0, driveGap = 0;
  logic [63:0] frameBits = '0;
  int busyCyc = 0, highCyc = 0, r8Viol = 0, conflict = 0;
  logic [1:0] prevLine = 2'b00;
  int checkCnt = 0, failCnt = 0, cyc = 0;

  always #10 clk = ~clk;

  assign mdioIn = mdioOe ? mdioOut : (phyDrv ? phyVal : 1'b1);

  mdio_master #(.HALF_DIV(H), .SYNC_STAGES(2)) dut (
    .clk(clk), .rstN(rstN), .start(start), .isWrite(isWrite),
    .phyAddr(phyAddr), .regAddr(regAddr), .wrData(wrData), .rdData(rdData),
    .busy(busy), .done(done), .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe),
    .mdioIn(mdioIn)
  );

  // PHY model: takes bits on rising edges, answers reads after rising edges
  always @(posedge mdc) begin
    if (mdioOe) begin
      if (riseCnt != drivenRises) driveGap = driveGap + 1;
      frameBits   = {frameBits[62:0], mdioOut};
      drivenRises = drivenRises + 1;
    end
    if (!curWr) begin
      if (riseCnt == 46) begin
        phyDrv = 1'b1; phyVal = 1'b0;
      end else if (riseCnt >= 47 && riseCnt <= 62) begin
        phyDrv = 1'b1; phyVal = phyPattern[62 - riseCnt];
      end else begin
        phyDrv = 1'b0;
      end
    end else begin
      phyDrv = 1'b0;
    end
    riseCnt = riseCnt + 1;
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
  endtask

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (busy) busyCyc = busyCyc + 1;
    if (busy && mdc) highCyc = highCyc + 1;
    if ({mdioOe, mdioOut} != prevLine && mdc) r8Viol = r8Viol + 1;
    if (mdioOe && phyDrv) conflict = conflict + 1;
    prevLine = {mdioOe, mdioOut};
    if (cyc == 150000) begin
      checkCnt = checkCnt + 1;
      failCnt  = failCnt + 1;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      summary();
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checkCnt = checkCnt + 1;
    if (!ok) begin
      failCnt = failCnt + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic doTxn(input bit wr, input logic [4:0] pa, input logic [4:0] ra,
                       input logic [15:0] wd, input logic [15:0] pat, input bit poke);
    logic [63:0] expFrame;
    int expRises, expDriven, waitCnt;
    bit seenDone;
    curWr = wr; phyPattern = pat;
    riseCnt = 0; drivenRises = 0; driveGap = 0; frameBits = '0;
    busyCyc = 0; highCyc = 0; r8Viol = 0; conflict = 0;
    @(negedge clk);
    start = 1'b1; isWrite = wr; phyAddr = pa; regAddr = ra; wrData = wd;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R10 busy after start", 64'(busy), 64'd1);
    if (poke) begin
      repeat (100) @(negedge clk);
      start = 1'b1; isWrite = ~wr; phyAddr = ~pa; regAddr = ~ra; wrData = ~wd;
      @(negedge clk);
      start = 1'b0;
    end
    seenDone = 1'b0;
    for (waitCnt = 0; waitCnt < 5000 && !seenDone; waitCnt++) begin
      @(negedge clk);
      if (done) seenDone = 1'b1;
    end
    check(seenDone, "R10 done seen", 64'(seenDone), 64'd1);
    check(busy == 1'b0, "R10 busy low at done", 64'(busy), 64'd0);
    expRises  = wr ? 65 : 64;
    expDriven = wr ? 64 : 46;
    if (wr) begin
      expFrame = {32'hFFFF_FFFF, 2'b01, 2'b01, pa, ra, 2'b10, wd};
      check(frameBits == expFrame, "R2 R3 R4 write frame bits", frameBits, expFrame);
      check(rdData == 16'h0, "R10 rdData after write", 64'(rdData), 64'h0);
    end else begin
      expFrame = {18'h0, 32'hFFFF_FFFF, 2'b01, 2'b10, pa, ra};
      check(frameBits[45:0] == expFrame[45:0], "R2 R3 read header bits",
            64'(frameBits[45:0]), expFrame);
      check(rdData == pat, "R5 read data", 64'(rdData), 64'(pat));
    end
    check(drivenRises == expDriven && driveGap == 0, "R4 R5 driven span",
          64'(drivenRises), 64'(expDriven));
    check(riseCnt == expRises, "R6 pulse count", 64'(riseCnt), 64'(expRises));
    check(busyCyc == expRises * 2 * H, "R7 busy length", 64'(busyCyc),
          64'(expRises * 2 * H));
    check(highCyc == expRises * H, "R7 mdc high time", 64'(highCyc), 64'(expRises * H));
    check(r8Viol == 0, "R8 line change with mdc high", 64'(r8Viol), 64'd0);
    check(conflict == 0, "R5 bus contention", 64'(conflict), 64'd0);
    @(negedge clk);
    check(done == 1'b0, "R10 done single cycle", 64'(done), 64'd0);
    check(mdc == 1'b0 && mdioOe == 1'b0, "R7 idle quiet", 64'({mdc, mdioOe}), 64'd0);
    if (poke) begin
      repeat (3) @(negedge clk);
      check(busy == 1'b0 && riseCnt == expRises, "R9 ignored start", 64'(busy), 64'd0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(mdc == 1'b0 && mdioOe == 1'b0 && busy == 1'b0 && done == 1'b0,
          "R1 in reset", 64'({mdc, mdioOe, busy, done}), 64'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(mdc == 1'b0 && mdioOe == 1'b0 && busy == 1'b0 && done == 1'b0,
          "R1 after reset", 64'({mdc, mdioOe, busy, done}), 64'd0);

    doTxn(1'b1, 5'd0,  5'd0,  16'h0000, 16'h0, 1'b0);
    doTxn(1'b1, 5'd31, 5'd31, 16'hFFFF, 16'h0, 1'b0);
    doTxn(1'b0, 5'd0,  5'd31, 16'h0,    16'h0000, 1'b0);
    doTxn(1'b0, 5'd31, 5'd0,  16'h0,    16'hFFFF, 1'b0);
    doTxn(1'b0, 5'd10, 5'd21, 16'h0,    16'hA55A, 1'b0);

    for (int i = 0; i < 32; i++) begin
      doTxn(1'b1, 5'(i), 5'(31 - i), 16'(16'h1357 * (i + 1)), 16'h0, 1'b0);
      doTxn(1'b0, 5'(i ^ 5), 5'(i), 16'h0, 16'(16'hA5C3 ^ (i * 16'h00F1)), 1'b0);
    end

    doTxn(1'b1, 5'd7, 5'd9,  16'h8001, 16'h0, 1'b1);
    doTxn(1'b0, 5'd3, 5'd17, 16'h0,    16'h6DB6, 1'b1);

    summary();
    $finish;
  end

endmodule